// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs an external 12-bit converter with a parallel result bus from the host side. It uses four control lines: an active-low select, an active-low convert start, an active-low read and a high-byte select. It also watches the converter's status line, which is low while a conversion runs and high once the result is ready. On a sample request the sequencer lowers select, sends a convert-start pulse, and then waits for the status line to rise. It then reads the result, either as one 12-bit word or as two byte reads over the low eight data lines. It returns the sample zero-extended to 16 bits with a one-cycle valid strobe.

All timing is counted in system clock cycles and derived from a clock-frequency parameter: the convert-start pulse width, the acquisition gap before the next conversion, and a timeout for a converter that never finishes. The status line comes from the converter's own clock domain, so it is synchronized before its edges are used. In free-running mode, select and read stay low. Conversions repeat back to back, and each result is taken straight off the bus when the status line rises.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is asserted, `adc_cs_n`, `adc_conv_n` and `adc_rd_n` are high, and `sample_vld` and `timeout_err` are low.
- R2: `adc_conv_n` falls only when `adc_cs_n` was already low in the preceding cycle.
- R3: Each convert-start low pulse lasts exactly `ceil(PULSE_NS*CLK_MHZ/1000)` clock cycles.
- R4: Between a convert start and the end of its sequence, there is no further falling edge of `adc_conv_n`. A `sample_req` raised during that time is dropped and yields no extra sample.
- R5: With `byte_mode`=0, `adc_rd_n` is driven low with `adc_hbyte`=0, and `sample` equals `{4'h0, adc_data[11:0]}`.
- R6: With `byte_mode`=1, the first read has `adc_hbyte`=0 and takes the low byte from `adc_data[7:0]`. The second read has `adc_hbyte`=1 and takes the high nibble from `adc_data[3:0]`. `sample` = `{4'h0, nibble, byte}`.
- R7: `sample_vld` is a single-cycle pulse, and `sample` holds the new result in that cycle.
- R8: A convert start comes no earlier than `ceil(ACQ_NS*CLK_MHZ/1000)` cycles after the previous rise of `adc_rdy`. A request made earlier is held and served once the gap has passed.
- R9: If `adc_rdy` has not risen within `ceil(TIMEOUT_NS*CLK_MHZ/1000)` cycles after the pulse, `timeout_err` goes high, no sample is returned and the sequencer returns to idle with `adc_cs_n` high. The flag clears when the next request is accepted.
- R10: While `free_run`=1, `adc_cs_n` and `adc_rd_n` stay low, conversions repeat without requests, and each sample is the bus value present when `adc_rdy` rises.
- R11: Boundary codes 0x000, 0x7FF, 0x800 and 0xFFF pass through unchanged in both read modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_req | input | 1 | One-cycle request for a conversion |
| byte_mode | input | 1 | 1: two byte reads, 0: one 12-bit read |
| free_run | input | 1 | 1: continuous conversions with select and read held low |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_conv_n | output | 1 | Convert start, conversion begins on its falling edge |
| adc_rd_n | output | 1 | Read enable, active low |
| adc_hbyte | output | 1 | 1 selects the high nibble on the byte bus |
| adc_rdy | input | 1 | Converter status, low while converting |
| adc_data | input | 12 | Converter result bus |
| sample | output | 16 | Zero-extended 12-bit result |
| sample_vld | output | 1 | One-cycle strobe for `sample` |
| timeout_err | output | 1 | Converter failed to finish in time |

## Verification
The bench builds the block with CLK_MHZ=125, PULSE_NS=24, ACQ_NS=80 and TIMEOUT_NS=400. This gives a 3-cycle pulse, a 10-cycle acquisition gap and a 50-cycle timeout. With these values, a bench converter model that takes 12 cycles can run many full sequences, back-to-back requests that hit the acquisition hold, a timeout and a free-running stretch, all within a short run. The defaults instead give a 5-cycle pulse, a 250-cycle gap and a 1250-cycle timeout, which would make each corner case take hundreds of cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEL   = 3'd1,
    ST_PULSE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_RDLO  = 3'd4,
    ST_RDHI  = 3'd5,
    ST_DONE  = 3'd6
  } seq_st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [15:0] word_from_bus(input logic [11:0] d);
    return {4'h0, d};
  endfunction

  function automatic logic [15:0] word_from_bytes(input logic [7:0] lo, input logic [3:0] hi);
    return {4'h0, hi, lo};
  endfunction

  function automatic logic sel_active(input seq_st_e st, input logic fr);
    return fr || (st != ST_IDLE);
  endfunction

  function automatic logic rd_active(input seq_st_e st, input logic fr);
    return fr || (st == ST_RDLO) || (st == ST_RDHI);
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      last <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      last <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] && !last;
endmodule

// File: rtl/adc_cyc_timer.sv
module adc_cyc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int PULSE_CYC = 5,
  parameter int TO_CYC    = 1250,
  parameter int RD_CYC    = 2,
  parameter int TW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_req,
  input  logic          byte_mode,
  input  logic          free_run,
  input  logic          busy_rise,
  input  logic [11:0]   adc_data,
  input  logic          seq_done,
  input  logic          acq_done,
  output logic          seq_load,
  output logic [TW-1:0] seq_val,
  output logic          acq_load,
  output logic          cs_n,
  output logic          conv_n,
  output logic          rd_n,
  output logic          hbyte,
  output logic [15:0]   sample,
  output logic          sample_vld,
  output logic          timeout_err,
  output logic          conv_inflight,
  output logic          fr_mode
);
  seq_st_e    st, st_d;
  logic       pend, fr_q, bm_q, go, fr_d, timeout_hit;
  logic [7:0] lo_byte;

  assign go          = (st == ST_IDLE) && (pend || sample_req || free_run) && acq_done;
  assign fr_d        = (st == ST_IDLE) ? free_run : fr_q;
  assign timeout_hit = (st == ST_WAIT) && !busy_rise && seq_done;

  always_comb begin
    st_d     = st;
    seq_load = 1'b0;
    seq_val  = '0;
    acq_load = 1'b0;
    unique case (st)
      ST_IDLE:  if (go) st_d = ST_SEL;
      ST_SEL: begin
        st_d     = ST_PULSE;
        seq_load = 1'b1;
        seq_val  = TW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (seq_done) begin
        st_d     = ST_WAIT;
        seq_load = 1'b1;
        seq_val  = TW'(TO_CYC - 1);
      end
      ST_WAIT: begin
        if (busy_rise) begin
          acq_load = 1'b1;
          if (fr_q) st_d = ST_DONE;
          else begin
            st_d     = ST_RDLO;
            seq_load = 1'b1;
            seq_val  = TW'(RD_CYC - 1);
          end
        end else if (seq_done) st_d = ST_IDLE;
      end
      ST_RDLO: if (seq_done) begin
        if (bm_q) begin
          st_d     = ST_RDHI;
          seq_load = 1'b1;
          seq_val  = TW'(RD_CYC - 1);
        end else st_d = ST_DONE;
      end
      ST_RDHI:  if (seq_done) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pend        <= 1'b0;
      fr_q        <= 1'b0;
      bm_q        <= 1'b0;
      lo_byte     <= '0;
      sample      <= '0;
      sample_vld  <= 1'b0;
      timeout_err <= 1'b0;
      cs_n        <= 1'b1;
      conv_n      <= 1'b1;
      rd_n        <= 1'b1;
      hbyte       <= 1'b0;
    end else begin
      st <= st_d;
      if (st != ST_IDLE || go) pend <= 1'b0;
      else if (sample_req)     pend <= 1'b1;
      if (st == ST_IDLE) begin
        fr_q <= free_run;
        bm_q <= byte_mode;
      end
      if (go)               timeout_err <= 1'b0;
      else if (timeout_hit) timeout_err <= 1'b1;
      if (st == ST_WAIT && busy_rise && fr_q) sample <= word_from_bus(adc_data);
      if (st == ST_RDLO && seq_done) begin
        if (bm_q) lo_byte <= adc_data[7:0];
        else      sample  <= word_from_bus(adc_data);
      end
      if (st == ST_RDHI && seq_done) sample <= word_from_bytes(lo_byte, adc_data[3:0]);
      sample_vld <= (st_d == ST_DONE);
      cs_n       <= !sel_active(st_d, fr_d);
      conv_n     <= (st_d != ST_PULSE);
      rd_n       <= !rd_active(st_d, fr_d);
      hbyte      <= (st_d == ST_RDHI);
    end
  end

  assign conv_inflight = (st == ST_WAIT);
  assign fr_mode       = fr_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int PULSE_NS   = 40,
  parameter int ACQ_NS     = 2000,
  parameter int TIMEOUT_NS = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_req,
  input  logic        byte_mode,
  input  logic        free_run,
  output logic        adc_cs_n,
  output logic        adc_conv_n,
  output logic        adc_rd_n,
  output logic        adc_hbyte,
  input  logic        adc_rdy,
  input  logic [11:0] adc_data,
  output logic [15:0] sample,
  output logic        sample_vld,
  output logic        timeout_err
);
  localparam int PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_MHZ);
  localparam int ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_MHZ);
  localparam int TO_CYC    = ns_to_cyc(TIMEOUT_NS, CLK_MHZ);
  localparam int RD_CYC    = 2;
  localparam int SEQ_MAX   = (TO_CYC > PULSE_CYC) ? TO_CYC : PULSE_CYC;
  localparam int TW        = $clog2(SEQ_MAX + RD_CYC + 1);
  localparam int AW        = $clog2(ACQ_CYC + 1);

  logic          busy_rise, seq_load, seq_done, acq_load, acq_done;
  logic [TW-1:0] seq_val;
  logic          conv_inflight, fr_mode;

  adc_busy_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(adc_rdy), .rise(busy_rise)
  );

  adc_cyc_timer #(.W(TW)) u_seq_tmr (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .load_val(seq_val), .done(seq_done)
  );

  adc_cyc_timer #(.W(AW)) u_acq_tmr (
    .clk(clk), .rst_n(rst_n), .load(acq_load), .load_val(AW'(ACQ_CYC - 1)), .done(acq_done)
  );

  adc_seq_fsm #(
    .PULSE_CYC(PULSE_CYC), .TO_CYC(TO_CYC), .RD_CYC(RD_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .byte_mode(byte_mode),
    .free_run(free_run), .busy_rise(busy_rise), .adc_data(adc_data),
    .seq_done(seq_done), .acq_done(acq_done), .seq_load(seq_load),
    .seq_val(seq_val), .acq_load(acq_load), .cs_n(adc_cs_n), .conv_n(adc_conv_n),
    .rd_n(adc_rd_n), .hbyte(adc_hbyte), .sample(sample), .sample_vld(sample_vld),
    .timeout_err(timeout_err), .conv_inflight(conv_inflight), .fr_mode(fr_mode)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int PULSE_CYC = 5,
  parameter int ACQ_CYC   = 250
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic conv_n,
  input logic rd_n,
  input logic vld,
  input logic err,
  input logic busy_rise,
  input logic conv_inflight,
  input logic fr_mode
);
  logic [15:0] lo_cnt, gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt  <= '0;
      gap_cnt <= '1;
    end else begin
      lo_cnt <= conv_n ? 16'd0 : lo_cnt + 16'd1;
      if (busy_rise)            gap_cnt <= '0;
      else if (gap_cnt != '1)   gap_cnt <= gap_cnt + 16'd1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (cs_n && conv_n && rd_n && !vld && !err));

  assert_cs_leads_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> $past(!cs_n));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> (lo_cnt == 16'(PULSE_CYC)));

  assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_inflight |-> conv_n);

  assert_vld_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  assert_acq_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> (gap_cnt >= 16'(ACQ_CYC)));

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err) && !fr_mode) |-> cs_n);

  assert_freerun_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fr_mode |-> (!cs_n && !rd_n));
endmodule

bind adc_seq_top adc_seq_chk #(.PULSE_CYC(PULSE_CYC), .ACQ_CYC(ACQ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .conv_n(adc_conv_n), .rd_n(adc_rd_n),
  .vld(sample_vld), .err(timeout_err), .busy_rise(busy_rise),
  .conv_inflight(conv_inflight), .fr_mode(fr_mode)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int TB_PULSE = 3;   // 24 ns at 125 MHz
  localparam int TB_ACQ   = 10;  // 80 ns
  localparam int TB_TO    = 50;  // 400 ns
  localparam int CONV_CYC = 12;

  // bit 12: byte mode, bits 11:0: converter code
  localparam logic [12:0] VEC [0:7] = '{
    13'h0_7FF, 13'h0_800, 13'h0_000, 13'h0_FFF,
    13'h1_7FF, 13'h1_800, 13'h1_A5C, 13'h1_FFF
  };

  logic        clk = 1'b0, rst_n = 1'b1;
  logic        sample_req = 1'b0, byte_mode = 1'b0, free_run = 1'b0;
  logic        adc_cs_n, adc_conv_n, adc_rd_n, adc_hbyte, sample_vld, timeout_err;
  logic [11:0] adc_data;
  logic [15:0] sample;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // converter model
  logic        m_rdy = 1'b1;
  logic [11:0] m_val = '0, m_res = '0;
  bit          m_dead = 0, m_bytebus = 0;
  int          m_cnt = 0, m_convs = 0;

  always #4 clk = ~clk;

  adc_seq_top #(.CLK_MHZ(125), .PULSE_NS(24), .ACQ_NS(80), .TIMEOUT_NS(400)) dut (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .byte_mode(byte_mode),
    .free_run(free_run), .adc_cs_n(adc_cs_n), .adc_conv_n(adc_conv_n),
    .adc_rd_n(adc_rd_n), .adc_hbyte(adc_hbyte), .adc_rdy(m_rdy), .adc_data(adc_data),
    .sample(sample), .sample_vld(sample_vld), .timeout_err(timeout_err)
  );

  assign adc_data = (!adc_cs_n && !adc_rd_n) ?
                    (m_bytebus ? (adc_hbyte ? {8'h00, m_res[11:8]} : {4'h0, m_res[7:0]}) : m_res)
                    : 12'h000;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // model and line monitor, on the falling edge
  logic prev_conv = 1'b1, prev_cs = 1'b1, prev_rd = 1'b1, prev_rdy = 1'b1;
  int   lo_len = 0, since_rdy = 100000;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_conv && !adc_conv_n) begin
        check(!prev_cs, "R2 select low before convert start", prev_cs, 0);
        check(since_rdy >= TB_ACQ, "R8 acquisition gap", since_rdy, TB_ACQ);
        if (!adc_cs_n && m_rdy && !m_dead) begin
          m_rdy   <= 1'b0;
          m_cnt   <= CONV_CYC;
          m_convs <= m_convs + 1;
        end
      end else if (!m_rdy) begin
        if (m_cnt == 1) begin
          m_rdy <= 1'b1;
          m_res <= m_val;
        end
        m_cnt <= m_cnt - 1;
      end
      if (!prev_conv && adc_conv_n)
        check(lo_len == TB_PULSE, "R3 convert pulse width", lo_len, TB_PULSE);
      if (prev_rd && !adc_rd_n && !free_run)
        check(!adc_hbyte, "R6 first read selects low byte", adc_hbyte, 0);
      lo_len    = adc_conv_n ? 0 : lo_len + 1;
      since_rdy = (!prev_rdy && m_rdy) ? 0 : since_rdy + 1;
    end
    prev_conv = adc_conv_n;
    prev_cs   = adc_cs_n;
    prev_rd   = adc_rd_n;
    prev_rdy  = m_rdy;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pulse_req();
    @(negedge clk) sample_req = 1'b1;
    @(negedge clk) sample_req = 1'b0;
  endtask

  task automatic wait_vld(output logic [15:0] s, output bit got);
    got = 0;
    s   = '0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      if (sample_vld) begin
        got = 1;
        s   = sample;
      end
    end
    if (got) begin
      @(negedge clk);
      check(!sample_vld, "R7 valid lasts one cycle", sample_vld, 0);
    end
  endtask

  initial begin
    logic [15:0] s;
    bit got;
    int n;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(adc_cs_n && adc_conv_n && adc_rd_n, "R1 lines idle in reset",
          {adc_cs_n, adc_conv_n, adc_rd_n}, 3'b111);
    check(!sample_vld && !timeout_err, "R1 flags low in reset",
          {sample_vld, timeout_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < 8; i++) begin
      byte_mode = VEC[i][12];
      m_bytebus = VEC[i][12];
      m_val     = VEC[i][11:0];
      pulse_req();
      wait_vld(s, got);
      check(got && s == {4'h0, VEC[i][11:0]},
            VEC[i][12] ? "R6 R11 byte-read sample" : "R5 R11 word-read sample",
            s, {4'h0, VEC[i][11:0]});
      repeat (20) @(negedge clk);
    end

    // request issued right after a result: must wait out acquisition (R8)
    byte_mode = 1'b0; m_bytebus = 0; m_val = 12'h123;
    pulse_req();
    wait_vld(s, got);
    m_val = 12'h456;
    pulse_req();
    wait_vld(s, got);
    check(got && s == 16'h0456, "R8 held request served", s, 16'h0456);
    repeat (20) @(negedge clk);

    // retrigger during a conversion is dropped (R4)
    n = m_convs;
    m_val = 12'h9AB;
    pulse_req();
    while (m_rdy) @(negedge clk);
    pulse_req();
    got = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (sample_vld) got = got + 1;
    end
    check(m_convs - n == 1, "R4 single conversion", m_convs - n, 1);
    check(sample == 16'h09AB, "R4 sample of single conversion", sample, 16'h09AB);

    // timeout (R9)
    m_dead = 1;
    pulse_req();
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sample_vld) n++;
    end
    check(timeout_err, "R9 timeout flag", timeout_err, 1);
    check(adc_cs_n, "R9 back to idle", adc_cs_n, 1);
    check(n == 0, "R9 no sample on timeout", n, 0);
    m_dead = 0;
    m_val = 12'h800;
    pulse_req();
    repeat (3) @(negedge clk);
    check(!timeout_err, "R9 flag cleared on accept", timeout_err, 0);
    wait_vld(s, got);
    check(got && s == 16'h0800, "R9 recovery sample", s, 16'h0800);
    repeat (20) @(negedge clk);

    // free running (R10)
    m_val = 12'h111;
    free_run = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_vld(s, got);
      check(got && s == {4'h0, m_val}, "R10 free-run sample", s, {4'h0, m_val});
      check(!adc_cs_n && !adc_rd_n, "R10 select and read held low",
            {adc_cs_n, adc_rd_n}, 0);
      m_val = m_val + 12'h111;
    end
    free_run = 1'b0;
    for (int i = 0; i < 200 && !adc_cs_n; i++) @(negedge clk);
    check(adc_cs_n && adc_rd_n, "R10 lines released after free run",
          {adc_cs_n, adc_rd_n}, 2'b11);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule